// File: doc/BRIEF.md
# Pipelined Residue-Three Reducer

This block computes the remainder of an unsigned N-bit operand divided by three. The work is spread over a chain of identical small lookup cells. Each cell takes the two-bit partial remainder from the cell before it and appends ALPHA fresh operand bits, taken most significant first. It then returns a new two-bit remainder, and a register follows every cell. One operand can enter on every clock. The result appears a fixed number of cycles later, with the input valid flag carried through the same stages.

The first cell sees only raw operand bits. Its upper two inputs can therefore hold the binary pattern 11, which no inner cell ever receives. The cell table is filled for every index, so one cell design serves in both places. When N−2 is not a multiple of ALPHA, the operand is widened with zeros at the top so that every cell consumes exactly ALPHA bits. Raising ALPHA cuts the number of stages, and each cell table grows as 2·2^(2+ALPHA) bits.

Top module: `mod3_cascade`

## Requirements
- R1: When `out_valid` is high, `out_res` equals the accepted operand modulo 3, encoded as unsigned binary 0, 1 or 2.
- R2: The result of an operand sampled with `in_valid` high at a rising edge appears on `out_res`/`out_valid` exactly S = ceil((N_BITS−2)/ALPHA) cycles after the cycle in which it was presented.
- R3: Operands may be presented on consecutive clocks without gaps, and every one produces its own result in order.
- R4: `out_valid` is low in every cycle whose corresponding input cycle had `in_valid` low; `out_res` carries no meaning then.
- R5: Reset is synchronous and active low. A rising edge with `rst_n` low clears every in-flight result, so no output is marked valid for operands presented at or before that edge.
- R6: Operands whose two top bits are both 1 (for N=8, values 192 to 255) reduce correctly, although the first cell's residue inputs then hold 3.
- R7: `out_res` never equals 3 while `out_valid` is high.
- R8: When N_BITS−2 is not a multiple of ALPHA, the zero-padded operand still gives the correct remainder for every value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand qualifier |
| in_x | input | N_BITS | Unsigned operand |
| out_valid | output | 1 | Result qualifier, delayed S cycles from `in_valid` |
| out_res | output | 2 | Operand modulo 3 |

## Verification
The bench builds two instances side by side. The first uses N_BITS=8 and ALPHA=1: six single-bit stages with no padding. It receives every operand value back to back, including the range where the head cell sees residue 3. The second uses N_BITS=13 and ALPHA=3: four stages with one pad bit on top. It receives all 8192 operands, which covers the padded path and the eight-entry-per-residue tables with wider cell indices. Gapped valid patterns and a reset asserted while results are in flight check that the qualifier tracks the data and that the pipeline is flushed.

// File: rtl/mod3_pkg.sv
// Package: shared types and table-generation helpers for the residue-three
// cascade. Assumes the modulus is fixed at three, so a residue fits in 2 bits.
package mod3_pkg;

    localparam int RES_W = 2;

    typedef logic [RES_W-1:0] res_t;

    // Number of lookup cells needed to absorb n operand bits, alpha per cell.
    function automatic int cell_count(input int n, input int alpha);
        return (n - RES_W + alpha - 1) / alpha;
    endfunction

    // Reduce an index by subtracting shifted multiples of three, high first.
    // Defined for every index, including ones an inner cell never sees.
    function automatic res_t reduce_index(input int y, input int idx_w);
        int acc;
        acc = y;
        for (int k = idx_w - 1; k >= 0; k--) begin
            if (acc >= (3 << k)) begin
                acc = acc - (3 << k);
            end
        end
        return res_t'(acc);
    endfunction

endpackage

// File: rtl/mod3_lut_cell.sv
// Combinational lookup cell: maps {residue, ALPHA new bits} to a new residue.
// The table is computed at elaboration. Entries whose residue field is 3 are
// filled with the true remainder, so the cell is also valid as the head cell.
module mod3_lut_cell
    import mod3_pkg::*;
#(
    parameter int ALPHA = 1
) (
    input  res_t             r_in,
    input  logic [ALPHA-1:0] grp,
    output res_t             r_out
);

    localparam int IDX_W = RES_W + ALPHA;
    localparam int DEPTH = 1 << IDX_W;

    // Build the flattened table, one residue per index.
    function automatic logic [RES_W*DEPTH-1:0] build_table();
        logic [RES_W*DEPTH-1:0] t;
        t = '0;
        for (int i = 0; i < DEPTH; i++) begin
            t[RES_W*i +: RES_W] = reduce_index(i, IDX_W);
        end
        return t;
    endfunction

    localparam logic [RES_W*DEPTH-1:0] TABLE = build_table();

    logic [IDX_W-1:0] idx;

    // Form the lookup index and read the table.
    always_comb begin
        idx   = {r_in, grp};
        r_out = TABLE[RES_W*idx +: RES_W];
    end

endmodule

// File: rtl/mod3_skew_reg.sv
// Plain data register that carries not-yet-consumed operand bits down the
// pipeline so they reach their cell in step with the residue. No reset:
// the contents only matter when the matching valid bit is set.
module mod3_skew_reg #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // Delay the remaining operand bits by one cycle.
    always_ff @(posedge clk) begin
        q <= d;
    end

endmodule

// File: rtl/mod3_stage.sv
// One pipeline stage: a lookup cell followed by a residue register and a
// valid register. Assumes r_in is below 3 except at the head stage.
module mod3_stage
    import mod3_pkg::*;
#(
    parameter int ALPHA = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             v_in,
    input  res_t             r_in,
    input  logic [ALPHA-1:0] grp,
    output logic             v_q,
    output res_t             r_q
);

    res_t r_next;

    mod3_lut_cell #(.ALPHA(ALPHA)) u_cell (
        .r_in  (r_in),
        .grp   (grp),
        .r_out (r_next)
    );

    // Valid register, cleared by synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= 1'b0;
        end else begin
            v_q <= v_in;
        end
    end

    // Residue register; data path is not reset.
    always_ff @(posedge clk) begin
        r_q <= r_next;
    end

    // R7
    stage_res_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v_q |-> (r_q != 2'b11));

    // R4
    stage_valid_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(v_q) |-> $past(v_in));

endmodule

// File: rtl/mod3_cascade.sv
// Top: residue-three reducer built from CELLS lookup stages. The operand is
// zero-padded at the top to RES_W + CELLS*ALPHA bits. The head stage takes
// the top two padded bits as its residue, and every stage consumes ALPHA
// bits, most significant first. Assumes N_BITS >= 3 and ALPHA >= 1.
module mod3_cascade
    import mod3_pkg::*;
#(
    parameter int N_BITS = 8,
    parameter int ALPHA  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [N_BITS-1:0] in_x,
    output logic              out_valid,
    output logic [1:0]        out_res
);

    localparam int CELLS = cell_count(N_BITS, ALPHA);
    localparam int PAD_W = RES_W + CELLS * ALPHA;
    localparam int PAD   = PAD_W - N_BITS;

    logic [PAD_W-1:0] x_pad;

    // Widen the operand with zeros on top when the bit count does not divide.
    if (PAD > 0) begin : g_pad
        assign x_pad = {{PAD{1'b0}}, in_x};
    end else begin : g_nopad
        assign x_pad = in_x;
    end

    for (genvar k = 0; k < CELLS; k++) begin : g_st
        localparam int REM_IN = (CELLS - k) * ALPHA;

        logic [REM_IN-1:0] rem_in;
        res_t              r_in;
        logic              v_in;
        res_t              r_q;
        logic              v_q;

        if (k == 0) begin : g_head
            assign rem_in = x_pad[REM_IN-1:0];
            assign r_in   = x_pad[PAD_W-1 -: RES_W];
            assign v_in   = in_valid;
        end else begin : g_link
            assign rem_in = g_st[k-1].g_rem.rem_q;
            assign r_in   = g_st[k-1].r_q;
            assign v_in   = g_st[k-1].v_q;
        end

        mod3_stage #(.ALPHA(ALPHA)) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .v_in  (v_in),
            .r_in  (r_in),
            .grp   (rem_in[REM_IN-1 -: ALPHA]),
            .v_q   (v_q),
            .r_q   (r_q)
        );

        if (k < CELLS - 1) begin : g_rem
            logic [REM_IN-ALPHA-1:0] rem_q;

            mod3_skew_reg #(.WIDTH(REM_IN - ALPHA)) u_skew (
                .clk (clk),
                .d   (rem_in[REM_IN-ALPHA-1:0]),
                .q   (rem_q)
            );
        end
    end

    assign out_valid = g_st[CELLS-1].v_q;
    assign out_res   = g_st[CELLS-1].r_q;

    // R5
    rst_flush_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R1
    res_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown(out_res));

    // R7
    out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_res <= 2'd2));

endmodule

// File: tb/tb_mod3_cascade.sv
`timescale 1ns/1ps
// Bench: two instances (8-bit/alpha 1 and 13-bit/alpha 3) driven every cycle,
// each checked against a queue-based delay model of its remainder.
module tb_mod3_cascade;

    localparam int NA = 8;
    localparam int AA = 1;
    localparam int LA = 6;   // ceil((8-2)/1)
    localparam int NB = 13;
    localparam int AB = 3;
    localparam int LB = 4;   // ceil((13-2)/3)

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n;
    logic          va, vb;
    logic [NA-1:0] xa;
    logic [NB-1:0] xb;
    logic          ova, ovb;
    logic [1:0]    ora, orb;

    mod3_cascade #(.N_BITS(NA), .ALPHA(AA)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(va), .in_x(xa),
        .out_valid(ova), .out_res(ora)
    );

    mod3_cascade #(.N_BITS(NB), .ALPHA(AB)) dut_pad (
        .clk(clk), .rst_n(rst_n), .in_valid(vb), .in_x(xb),
        .out_valid(ovb), .out_res(orb)
    );

    int vectors = 0;
    int fails   = 0;
    int qa_v[$], qa_r[$], qa_x[$];
    int qb_v[$], qb_r[$], qb_x[$];

    // Compare the 8-bit instance against the entry presented LA cycles ago.
    task automatic check_a();
        int ev, er, ex;
        if (qa_v.size() == LA) begin
            ev = qa_v.pop_front(); er = qa_r.pop_front(); ex = qa_x.pop_front();
            vectors++;
            if (ova !== ev[0]) begin
                fails++;
                $display("FAIL R2 R4 R5 dut valid x=%0d got %b exp %0d", ex, ova, ev);
            end else if (ev != 0 && ova && ora == 2'b11) begin
                fails++;
                $display("FAIL R7 dut x=%0d got %0d exp %0d", ex, ora, er);
            end else if (ev != 0 && ora !== er[1:0]) begin
                fails++;
                if (ex >= 192)
                    $display("FAIL R6 dut x=%0d got %0d exp %0d", ex, ora, er);
                else
                    $display("FAIL R1 R3 dut x=%0d got %0d exp %0d", ex, ora, er);
            end
        end
    endtask

    // Compare the padded 13-bit instance against its LB-cycle-old entry.
    task automatic check_b();
        int ev, er, ex;
        if (qb_v.size() == LB) begin
            ev = qb_v.pop_front(); er = qb_r.pop_front(); ex = qb_x.pop_front();
            vectors++;
            if (ovb !== ev[0]) begin
                fails++;
                $display("FAIL R2 R4 dut_pad valid x=%0d got %b exp %0d", ex, ovb, ev);
            end else if (ev != 0 && orb !== er[1:0]) begin
                fails++;
                $display("FAIL R8 dut_pad x=%0d got %0d exp %0d", ex, orb, er);
            end
        end
    endtask

    // One cycle: check outputs, drive new inputs, record expected results.
    task automatic step(input logic r, input logic a_v, input int a_x,
                        input logic b_v, input int b_x);
        @(negedge clk);
        check_a();
        check_b();
        rst_n = r;
        va = a_v; xa = NA'(a_x);
        vb = b_v; xb = NB'(b_x);
        if (!r) begin
            foreach (qa_v[i]) qa_v[i] = 0;
            foreach (qb_v[i]) qb_v[i] = 0;
        end
        qa_v.push_back((a_v && r) ? 1 : 0);
        qa_r.push_back(a_x % 3);
        qa_x.push_back(a_x);
        qb_v.push_back((b_v && r) ? 1 : 0);
        qb_r.push_back(b_x % 3);
        qb_x.push_back(b_x);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R3 watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0; va = 1'b0; vb = 1'b0; xa = '0; xb = '0;
        for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 255, 1'b1, 8191);

        // R5: reset state at the ports
        @(negedge clk);
        vectors++;
        if (ova !== 1'b0 || ovb !== 1'b0) begin
            fails++;
            $display("FAIL R5 reset state got %b%b exp 00", ova, ovb);
        end

        // R1 R3 R6: every 8-bit operand back to back
        for (int i = 0; i < 256; i++) step(1'b1, 1'b1, i, 1'b1, 8191 - i);

        // R4: gapped valid patterns
        for (int i = 0; i < 200; i++)
            step(1'b1, (i % 3) != 0, (i * 37 + 11) & 255, (i % 2) == 1, (i * 101) & 8191);

        // R5: reset while results are in flight
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 200 + i, 1'b1, 4000 + i);
        step(1'b0, 1'b1, 250, 1'b1, 5000);
        step(1'b0, 1'b1, 251, 1'b1, 5001);
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 240 + i, 1'b1, 6000 + i);

        // R2 R6: isolated operand after idle
        for (int i = 0; i < LA + 2; i++) step(1'b1, 1'b0, 0, 1'b0, 0);
        step(1'b1, 1'b1, 255, 1'b1, 8191);
        for (int i = 0; i < LA + 2; i++) step(1'b1, 1'b0, 0, 1'b0, 0);

        // R8: every 13-bit operand through the padded instance
        for (int i = 0; i < 8192; i++) step(1'b1, 1'b1, (i * 73) & 255, 1'b1, i);

        for (int i = 0; i < LA + 4; i++) step(1'b1, 1'b0, 0, 1'b0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule